// File: doc/BRIEF.md
# Flattened Butterfly Adaptive Route Selector

This block is the route-computation stage of one router in a flattened butterfly network. A node address is a string of radix-K digits, one digit per dimension. Within a dimension each router has a direct link to every other router in that dimension. One hop therefore fixes one differing digit, and the digits may be fixed in any order. For each accepted packet header the block compares the target digits with the router's own coordinates. It then registers an output port together with the updated routing state of the header: a phase bit and an intermediate address.

Three routing policies are selectable at run time:

- **Minimal adaptive.** Among the productive ports, it takes the one whose output queue is least occupied.
- **Valiant.** At the packet's first hop it draws a random intermediate node from an internal 16-bit LFSR. The packet travels minimally to that node and then minimally on to its destination.
- **UGAL.** At the first hop it weighs queue occupancy times hop count for the minimal route against the same product for the route through a random intermediate node. It takes the cheaper of the two.

A downstream stall freezes the decision and the random source.

Top module: `fb_route_sel`

## Requirements
- R1: While reset is asserted and after it is released, `rt_valid` is 0, and the LFSR holds the seed value (default 16'h1D2B).
- R2: A header presented with `hdr_valid`=1 and `stall`=0 yields `rt_valid`=1 with its decision on the next cycle. A cycle with `stall`=0 and `hdr_valid`=0 yields `rt_valid`=0 on the next cycle.
- R3: While `stall`=1, the registers `rt_valid`, `rt_port`, `rt_phase` and `rt_mid` and the LFSR keep their values. Any header presented during the stall is discarded.
- R4: Port 0 is ejection. To set dimension d (digit at address bits [d*DW +: DW], DW = clog2(K)) from local digit u to digit v, the port is 1 + d*(K-1) + (v<u ? v : v-1).
- R5: When routing minimally toward a target, the chosen port is the productive port with the smallest occupancy. Port p's occupancy is `q_occ[p*QW +: QW]`. Ties go to the lowest dimension.
- R6: When the target equals `my_coord` and the outgoing phase is 0, `rt_port` is 0.
- R7: With `hdr_phase`=1, if `my_coord` equals `hdr_mid` then `rt_phase` becomes 0 and routing targets `hdr_dst`. Otherwise `rt_phase` stays 1 and routing targets `hdr_mid`.
- R8: In Valiant mode (`mode`=1), consider a first-hop header (`hdr_first`=1, `hdr_phase`=0) whose destination is not local. It receives `rt_mid` = the drawn node, `rt_phase`=1, and a minimal-adaptive port toward that node. If the drawn node equals `my_coord`, it is routed minimally with `rt_phase`=0.
- R9: The LFSR advances once per accepted header, as s' = {s[14:0], s[15]^s[13]^s[12]^s[10]}, and is never zero. Drawn digit d is (s[d*SLW +: SLW]) mod K, with SLW = 16/NDIM, taken from the value before the advance.
- R10: In UGAL mode (`mode`=2), a first-hop header with a non-local destination and a drawn node other than `my_coord` takes the non-minimal path when qmin*Hmin > qnm*Hnm, and only then. Here qmin and qnm are the occupancies of the ports R5 picks toward the destination and toward the drawn node. Hmin is the count of differing digits to the destination. Hnm is the count to the drawn node plus the count from it to the destination.
- R11: In modes 0 and 3, a first-hop header never sets `rt_phase`. In every mode, a first-hop header whose destination is local ejects with `rt_phase`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold all outputs and the random source |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_first | input | 1 | Header is at its injection router |
| hdr_phase | input | 1 | Header is still heading to its intermediate node |
| hdr_dst | input | NDIM*clog2(K) | Final destination address |
| hdr_mid | input | NDIM*clog2(K) | Intermediate address carried by the header |
| my_coord | input | NDIM*clog2(K) | Coordinates of this router |
| mode | input | 2 | 0 minimal adaptive, 1 Valiant, 2 UGAL, 3 minimal adaptive |
| q_occ | input | (1+NDIM*(K-1))*QW | Queue occupancy per output port |
| rt_valid | output | 1 | Decision valid |
| rt_port | output | clog2(1+NDIM*(K-1)) | Chosen output port |
| rt_phase | output | 1 | Updated phase bit |
| rt_mid | output | NDIM*clog2(K) | Updated intermediate address |

## Verification
A corrupted LFSR shows up at the ports on the next Valiant or UGAL first hop as a wrong `rt_mid`. A frozen or over-advanced LFSR does the same, and the error persists on every later draw. A wrong productive-port choice or tie-break appears in `rt_port` one cycle after the header. A phase bit that fails to clear at the intermediate node appears as a wrong `rt_phase`, together with a port aimed at the old target. A stall that leaks shows up within the stalled cycles as changed outputs, or later as a shifted random sequence.

// File: rtl/fb_route_pkg.sv
package fb_route_pkg;
  localparam int LFSR_W = 16;

  typedef enum logic [1:0] {
    RT_MINADAPT = 2'd0,
    RT_VALIANT  = 2'd1,
    RT_UGAL     = 2'd2,
    RT_MINALT   = 2'd3
  } rt_mode_e;
endpackage

// File: rtl/fb_lfsr16.sv
module fb_lfsr16 #(
  parameter logic [15:0] SEED = 16'h1D2B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [15:0] state
);
  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= step(state);
  end
endmodule

// File: rtl/fb_min_pick.sv
module fb_min_pick #(
  parameter int K    = 4,
  parameter int NDIM = 3,
  parameter int QW   = 6,
  localparam int DW    = $clog2(K),
  localparam int AW    = NDIM * DW,
  localparam int NPORT = 1 + NDIM * (K - 1),
  localparam int PW    = $clog2(NPORT),
  localparam int HW    = $clog2(2 * NDIM + 1)
) (
  input  logic [AW-1:0]       here,
  input  logic [AW-1:0]       tgt,
  input  logic [NPORT*QW-1:0] q_occ,
  output logic                at_tgt,
  output logic [PW-1:0]       port,
  output logic [QW-1:0]       occ,
  output logic [HW-1:0]       hops
);
  function automatic logic [PW-1:0] port_of(input int d, input logic [DW-1:0] u,
                                             input logic [DW-1:0] v);
    int idx;
    idx = 1 + d * (K - 1) + ((v < u) ? int'(v) : int'(v) - 1);
    return PW'(idx);
  endfunction

  logic [NDIM-1:0] cand_diff;
  logic [PW-1:0]   cand_port [NDIM];
  logic [QW-1:0]   cand_occ  [NDIM];

  genvar d;
  generate
    for (d = 0; d < NDIM; d++) begin : g_dim
      assign cand_diff[d] = here[d*DW +: DW] != tgt[d*DW +: DW];
      assign cand_port[d] = port_of(d, here[d*DW +: DW], tgt[d*DW +: DW]);
      assign cand_occ[d]  = q_occ[int'(cand_port[d])*QW +: QW];
    end
  endgenerate

  always_comb begin
    logic found;
    found = 1'b0;
    port  = '0;
    occ   = '0;
    hops  = '0;
    for (int i = 0; i < NDIM; i++) begin
      if (cand_diff[i]) begin
        hops = hops + HW'(1);
        if (!found || cand_occ[i] < occ) begin
          found = 1'b1;
          port  = cand_port[i];
          occ   = cand_occ[i];
        end
      end
    end
  end

  assign at_tgt = (here == tgt);
endmodule

// File: rtl/fb_ugal_cmp.sv
module fb_ugal_cmp #(
  parameter int K    = 4,
  parameter int NDIM = 3,
  parameter int QW   = 6,
  localparam int DW  = $clog2(K),
  localparam int AW  = NDIM * DW,
  localparam int HW  = $clog2(2 * NDIM + 1),
  localparam int PRW = QW + HW
) (
  input  logic [QW-1:0] q_min,
  input  logic [HW-1:0] h_min,
  input  logic [QW-1:0] q_nm,
  input  logic [HW-1:0] h_to_mid,
  input  logic [AW-1:0] mid,
  input  logic [AW-1:0] dst,
  output logic          take_nm
);
  function automatic logic [HW-1:0] diff_cnt(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [HW-1:0] n;
    n = '0;
    for (int i = 0; i < NDIM; i++)
      if (a[i*DW +: DW] != b[i*DW +: DW]) n = n + HW'(1);
    return n;
  endfunction

  logic [HW-1:0]  h_nm;
  logic [PRW-1:0] cost_min, cost_nm;

  assign h_nm     = h_to_mid + diff_cnt(mid, dst);
  assign cost_min = PRW'(q_min) * PRW'(h_min);
  assign cost_nm  = PRW'(q_nm) * PRW'(h_nm);
  assign take_nm  = cost_min > cost_nm;
endmodule

// File: rtl/fb_route_sel.sv
module fb_route_sel
  import fb_route_pkg::*;
#(
  parameter int          K         = 4,
  parameter int          NDIM      = 3,
  parameter int          QW        = 6,
  parameter logic [15:0] LFSR_SEED = 16'h1D2B,
  localparam int DW    = $clog2(K),
  localparam int AW    = NDIM * DW,
  localparam int NPORT = 1 + NDIM * (K - 1),
  localparam int PW    = $clog2(NPORT),
  localparam int HW    = $clog2(2 * NDIM + 1),
  localparam int SLW   = LFSR_W / NDIM
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall,
  input  logic                hdr_valid,
  input  logic                hdr_first,
  input  logic                hdr_phase,
  input  logic [AW-1:0]       hdr_dst,
  input  logic [AW-1:0]       hdr_mid,
  input  logic [AW-1:0]       my_coord,
  input  logic [1:0]          mode,
  input  logic [NPORT*QW-1:0] q_occ,
  output logic                rt_valid,
  output logic [PW-1:0]       rt_port,
  output logic                rt_phase,
  output logic [AW-1:0]       rt_mid
);
  function automatic logic [AW-1:0] node_from(input logic [LFSR_W-1:0] s);
    logic [AW-1:0] r;
    int            slice;
    r = '0;
    for (int i = 0; i < NDIM; i++) begin
      slice = int'(s >> (i * SLW)) & ((1 << SLW) - 1);
      r[i*DW +: DW] = DW'(slice % K);
    end
    return r;
  endfunction

  rt_mode_e mode_e;
  assign mode_e = rt_mode_e'(mode);

  // named internal events
  logic          accept, mid_reached, fresh, draw_mid, take_nm;
  logic [15:0]   lfsr_q;
  logic [AW-1:0] rnd_node, cont_tgt;
  logic          cont_phase;

  assign accept      = hdr_valid && !stall;
  assign mid_reached = hdr_phase && (my_coord == hdr_mid);
  assign cont_phase  = hdr_phase && !mid_reached;
  assign cont_tgt    = cont_phase ? hdr_mid : hdr_dst;
  assign rnd_node    = node_from(lfsr_q);

  fb_lfsr16 #(.SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(accept), .state(lfsr_q)
  );

  logic          a_at, b_at;
  logic [PW-1:0] a_port, b_port;
  logic [QW-1:0] a_occ, b_occ;
  logic [HW-1:0] a_hops, b_hops;

  fb_min_pick #(.K(K), .NDIM(NDIM), .QW(QW)) u_pick_tgt (
    .here(my_coord), .tgt(cont_tgt), .q_occ(q_occ),
    .at_tgt(a_at), .port(a_port), .occ(a_occ), .hops(a_hops)
  );

  fb_min_pick #(.K(K), .NDIM(NDIM), .QW(QW)) u_pick_rnd (
    .here(my_coord), .tgt(rnd_node), .q_occ(q_occ),
    .at_tgt(b_at), .port(b_port), .occ(b_occ), .hops(b_hops)
  );

  fb_ugal_cmp #(.K(K), .NDIM(NDIM), .QW(QW)) u_ugal (
    .q_min(a_occ), .h_min(a_hops), .q_nm(b_occ), .h_to_mid(b_hops),
    .mid(rnd_node), .dst(hdr_dst), .take_nm(take_nm)
  );

  assign fresh    = hdr_first && !hdr_phase && (my_coord != hdr_dst) && !b_at;
  assign draw_mid = fresh && ((mode_e == RT_VALIANT) || (mode_e == RT_UGAL && take_nm));

  logic [PW-1:0] nxt_port;
  logic          nxt_phase;
  logic [AW-1:0] nxt_mid;

  always_comb begin
    if (draw_mid) begin
      nxt_port  = b_port;
      nxt_phase = 1'b1;
      nxt_mid   = rnd_node;
    end else begin
      nxt_port  = a_at ? '0 : a_port;
      nxt_phase = cont_phase;
      nxt_mid   = hdr_mid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_valid <= 1'b0;
      rt_port  <= '0;
      rt_phase <= 1'b0;
      rt_mid   <= '0;
    end else if (!stall) begin
      rt_valid <= hdr_valid;
      if (hdr_valid) begin
        rt_port  <= nxt_port;
        rt_phase <= nxt_phase;
        rt_mid   <= nxt_mid;
      end
    end
  end
endmodule

// File: rtl/fb_route_sel_chk.sv
module fb_route_sel_chk #(
  parameter int K    = 4,
  parameter int NDIM = 3,
  localparam int DW    = $clog2(K),
  localparam int AW    = NDIM * DW,
  localparam int NPORT = 1 + NDIM * (K - 1),
  localparam int PW    = $clog2(NPORT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          hdr_valid,
  input logic          hdr_phase,
  input logic [1:0]    mode,
  input logic          rt_valid,
  input logic [PW-1:0] rt_port,
  input logic          rt_phase,
  input logic [AW-1:0] rt_mid,
  input logic [15:0]   lfsr_q,
  input logic          accept,
  input logic          draw_mid,
  input logic          mid_reached
);
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rt_valid); // R2
  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !hdr_valid) |=> !rt_valid); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(rt_valid) && $stable(rt_port) && $stable(rt_phase) && $stable(rt_mid))); // R3
  AST_PORT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> (int'(rt_port) < NPORT)); // R4
  AST_MID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mid_reached) |=> !rt_phase); // R7
  AST_DRAW_SETS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && draw_mid) |=> (rt_phase && rt_port != '0)); // R8
  AST_LFSR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(lfsr_q)); // R9
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0); // R9
  AST_MIN_NO_DRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hdr_phase && (mode == 2'd0 || mode == 2'd3)) |=> !rt_phase); // R11
endmodule

bind fb_route_sel fb_route_sel_chk #(.K(K), .NDIM(NDIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .hdr_valid(hdr_valid),
  .hdr_phase(hdr_phase), .mode(mode), .rt_valid(rt_valid), .rt_port(rt_port),
  .rt_phase(rt_phase), .rt_mid(rt_mid), .lfsr_q(lfsr_q), .accept(accept),
  .draw_mid(draw_mid), .mid_reached(mid_reached)
);

// File: tb/sim_fb_route_sel.sv
module sim_fb_route_sel;
  localparam int K     = 4;
  localparam int NDIM  = 3;
  localparam int QW    = 6;
  localparam int DW    = $clog2(K);
  localparam int AW    = NDIM * DW;
  localparam int NPORT = 1 + NDIM * (K - 1);
  localparam int PW    = $clog2(NPORT);
  localparam int SLW   = 16 / NDIM;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, stall, hdr_valid, hdr_first, hdr_phase;
  logic [AW-1:0] hdr_dst, hdr_mid, my_coord;
  logic [1:0] mode;
  logic [NPORT*QW-1:0] q_occ;
  logic rt_valid, rt_phase;
  logic [PW-1:0] rt_port;
  logic [AW-1:0] rt_mid;

  fb_route_sel u0 (.*);

  int nchk = 0, nerr = 0;
  int qa [NPORT];
  logic [15:0] lf;
  bit exp_valid, exp_phase;
  int exp_port;
  logic [AW-1:0] exp_mid;
  string exp_tag;
  bit done = 1'b0;

  function automatic logic [15:0] lf_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [AW-1:0] drawn(input logic [15:0] s);
    logic [AW-1:0] r = '0;
    for (int d = 0; d < NDIM; d++) r[d*DW +: DW] = DW'(((int'(s) >> (d*SLW)) % (1 << SLW)) % K);
    return r;
  endfunction

  function automatic int ndiff(input logic [AW-1:0] a, input logic [AW-1:0] b);
    int n = 0;
    for (int d = 0; d < NDIM; d++) if (a[d*DW +: DW] != b[d*DW +: DW]) n++;
    return n;
  endfunction

  // walk all ports, decode the digit each one reaches, keep the least busy productive one
  task automatic best(input logic [AW-1:0] my, input logic [AW-1:0] tgt, output int bp, output int bq);
    bp = -1; bq = 0;
    for (int p = 1; p < NPORT; p++) begin
      int d = (p - 1) / (K - 1);
      int off = (p - 1) % (K - 1);
      int u = int'(my[d*DW +: DW]);
      int v = (off < u) ? off : off + 1;
      if (v == int'(tgt[d*DW +: DW]) && v != u && (bp < 0 || qa[p] < bq)) begin
        bp = p; bq = qa[p];
      end
    end
  endtask

  task automatic model(input bit fi, input bit ph, input logic [AW-1:0] dst, input logic [AW-1:0] mid,
                       input logic [AW-1:0] my, input logic [1:0] md);
    bit reached = ph && (my == mid);
    bit cph = ph && !reached;
    logic [AW-1:0] tgt = cph ? mid : dst;
    int ap, aq, bp, bq;
    best(my, tgt, ap, aq);
    exp_port = (ap < 0) ? 0 : ap;
    exp_phase = cph;
    exp_mid = mid;
    exp_tag = (ap < 0) ? "R6" : (reached ? "R7" : "R5");
    if (fi && !ph && my == dst) exp_tag = "R11";
    if (fi && !ph && my != dst && (md == 2'd1 || md == 2'd2)) begin
      logic [AW-1:0] r = drawn(lf);
      exp_tag = (md == 2'd1) ? "R8" : "R10";
      if (r != my) begin
        int hn = ndiff(my, r) + ndiff(r, dst);
        best(my, r, bp, bq);
        if (md == 2'd1 || aq * ndiff(my, dst) > bq * hn) begin
          exp_port = bp; exp_phase = 1'b1; exp_mid = r;
        end
      end
    end
  endtask

  task automatic check_out();
    nchk++;
    if (rt_valid !== exp_valid ||
        (exp_valid && (int'(rt_port) != exp_port || rt_phase !== exp_phase || rt_mid !== exp_mid))) begin
      nerr++;
      $display("FAIL %s: actual valid=%0d port=%0d phase=%0d mid=%h expected valid=%0d port=%0d phase=%0d mid=%h",
               exp_tag, rt_valid, rt_port, rt_phase, rt_mid, exp_valid, exp_port, exp_phase, exp_mid);
    end
  endtask

  task automatic cyc(input bit st, input bit hv, input bit fi, input bit ph, input logic [AW-1:0] dst,
                     input logic [AW-1:0] mid, input logic [AW-1:0] my, input logic [1:0] md, input string tg);
    check_out();
    stall = st; hdr_valid = hv; hdr_first = fi; hdr_phase = ph;
    hdr_dst = dst; hdr_mid = mid; my_coord = my; mode = md;
    for (int p = 0; p < NPORT; p++) q_occ[p*QW +: QW] = QW'(qa[p]);
    if (st) exp_tag = "R3";
    else begin
      exp_valid = hv;
      exp_tag = "R2";
      if (hv) begin
        model(fi, ph, dst, mid, my, md);
        lf = lf_next(lf);
        if (tg != "") exp_tag = tg;
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    logic [AW-1:0] a;
    for (int d = 0; d < NDIM; d++) a[d*DW +: DW] = DW'($urandom % K);
    return a;
  endfunction

  function automatic logic [AW-1:0] at3(input int d2, input int d1, input int d0);
    return {DW'(d2), DW'(d1), DW'(d0)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; stall = 1'b0; hdr_valid = 1'b0; hdr_first = 1'b0; hdr_phase = 1'b0;
    hdr_dst = '0; hdr_mid = '0; my_coord = '0; mode = '0; q_occ = '0;
    for (int p = 0; p < NPORT; p++) qa[p] = 0;
    lf = 16'h1D2B;  // R1 seed, verified by the first draws below
    exp_valid = 1'b0; exp_port = 0; exp_phase = 1'b0; exp_mid = '0; exp_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_tag = "R1";
    // R4: only dim1 differs, 0 -> 3, port 1+3+2 = 6
    cyc(0, 1, 0, 0, at3(0, 3, 0), '0, at3(0, 0, 0), 2'd0, "R4");
    // R5 tie: all dims differ, equal queues -> dim0 port 1+0+(2-1)=2
    for (int p = 0; p < NPORT; p++) qa[p] = 5;
    cyc(0, 1, 0, 0, at3(3, 0, 2), '0, at3(1, 1, 1), 2'd0, "R5");
    // R5 least busy: dim2 port 1+6+(3-1)=9 is cheaper
    qa[9] = 1;
    cyc(0, 1, 0, 0, at3(3, 0, 2), '0, at3(1, 1, 1), 2'd0, "R5");
    // R6 / R11: local destination ejects in Valiant mode
    cyc(0, 1, 1, 0, at3(2, 2, 2), '0, at3(2, 2, 2), 2'd1, "R11");
    // R7: reached intermediate -> phase clears, route to dst
    cyc(0, 1, 0, 1, at3(0, 0, 3), at3(1, 2, 3), at3(1, 2, 3), 2'd2, "R7");
    // R7: not reached -> keep heading to mid
    cyc(0, 1, 0, 1, at3(0, 0, 3), at3(1, 2, 3), at3(1, 2, 0), 2'd0, "R7");
    // R8 / R9: Valiant draws from the LFSR
    cyc(0, 1, 1, 0, at3(3, 3, 3), '0, at3(0, 0, 0), 2'd1, "R8");
    cyc(0, 1, 1, 0, at3(3, 3, 3), '0, at3(0, 0, 0), 2'd1, "R9");
    // R10: heavy minimal queues vs idle elsewhere, then reversed
    for (int p = 0; p < NPORT; p++) qa[p] = 0;
    qa[3] = 60; qa[6] = 60; qa[9] = 60;
    cyc(0, 1, 1, 0, at3(3, 3, 3), '0, at3(0, 0, 0), 2'd2, "R10");
    for (int p = 0; p < NPORT; p++) qa[p] = 40;
    qa[3] = 0; qa[6] = 0; qa[9] = 0;
    cyc(0, 1, 1, 0, at3(3, 3, 3), '0, at3(0, 0, 0), 2'd2, "R10");
    // R3: stall holds outputs and drops header; LFSR must not advance
    cyc(1, 1, 1, 0, at3(1, 1, 1), '0, at3(0, 0, 0), 2'd1, "R3");
    cyc(1, 1, 1, 0, at3(2, 1, 1), '0, at3(0, 0, 0), 2'd1, "R3");
    cyc(1, 0, 0, 0, '0, '0, '0, 2'd0, "R3");
    // R2: idle cycle drops valid
    cyc(0, 0, 0, 0, '0, '0, '0, 2'd0, "R2");
    // R9: draw after the stall uses the unadvanced LFSR
    cyc(0, 1, 1, 0, at3(3, 2, 1), '0, at3(1, 2, 3), 2'd1, "R9");
    // R11: minimal modes never draw
    cyc(0, 1, 1, 0, at3(3, 2, 1), '0, at3(1, 2, 3), 2'd3, "R11");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit st = ($urandom % 6) == 0;
      bit hv = ($urandom % 4) != 0;
      bit ph = ($urandom % 3) == 0;
      bit fi = ph ? 1'b0 : ($urandom % 2 == 1);
      logic [AW-1:0] my = rnd_addr();
      logic [AW-1:0] dst = (($urandom % 8) == 0) ? my : rnd_addr();
      logic [AW-1:0] mid = (ph && ($urandom % 4) == 0) ? my : rnd_addr();
      int qmax = (n % 2 == 0) ? 4 : 64;
      for (int p = 0; p < NPORT; p++) qa[p] = $urandom % qmax;
      cyc(st, hv, fi, ph, dst, mid, my, 2'($urandom % 4), "");
    end
    check_out();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule